// File: doc/BRIEF.md
# Reverse-Order Suffix-Insertion BWT Engine

This block computes the Burrows-Wheeler Transform of one block of bytes. It stores the block in an on-chip symbol buffer. It then walks the buffer from the last byte back to the first. For each byte it adds one suffix to an ordered linked list of suffixes. A sentinel symbol is placed after the final byte. The sentinel compares greater than all 256 byte values, so no two rotations are equal. When the first byte has been handled, the list holds every rotation in sorted order. The engine walks the list once and streams out the symbol that comes before each rotation. This stream is the last column of the sorted rotation matrix. The final beat also carries the row number of the unrotated string.

The position of each new suffix comes from two sources. The first is a scan of the list from its head up to the suffix that follows it in the string. The second is a table that records, for each byte value, the suffix that currently sorts last among those starting with that value. No comparison sort is performed. Input is a byte stream with valid/ready handshake and an end-of-block flag. A block of MAX_LEN bytes closes by itself. The output stream has no backpressure.

Top module: `bwt_ass_engine`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `out_last` and `idx_valid` are 0.
- R2: A byte is taken on each clock edge where `in_valid` and `in_ready` are both 1. The block ends at the beat that carries `in_last`, or at the MAX_LEN-th byte if `in_last` has not been seen. A block of L bytes produces exactly L+1 output beats.
- R3: `in_ready` stays 0 from the clock after the final byte is taken through the cycle in which `idx_valid` is 1.
- R4: Output beats follow the ascending order of the L+1 rotations of the block followed by the sentinel. The sentinel ranks above byte 0xFF. Each beat carries the symbol just before that rotation's starting position.
- R5: A sentinel beat is marked by `out_sent` = 1 with `out_data` = 0. Each block has exactly one such beat.
- R6: `out_last` is 1 on the final beat only. `idx_valid` is 1 in exactly that cycle and in no other.
- R7: `idx` (valid with `idx_valid`) is the zero-based position, among the sorted rotations, of the rotation that starts at byte 0.
- R8: Results are correct for degenerate blocks: a single byte, a block of one repeated byte value, and periodic strings.
- R9: In the cycle after `idx_valid`, `in_ready` returns to 1. The next block's result does not depend on any earlier block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine can take a byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a block |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 8 | Last-column byte, 0 when the beat is the sentinel |
| out_sent | output | 1 | Beat stands for the sentinel |
| out_last | output | 1 | Final beat of the block |
| idx_valid | output | 1 | Primary index valid |
| idx | output | IW = clog2(MAX_LEN+2) | Primary index |

## Verification
An error in the suffix list or the per-symbol tail table changes where the next suffix is inserted. That misplacement stays in the list until the block ends. It therefore shows up as a reordered output stream and often as a wrong index. The effect is visible only during readout, which starts roughly L²/2 cycles after the bad insertion. The directed blocks are chosen to reach each insertion path: first use of a byte value, insertion in the middle of a group, a new group tail, and insertion at the list head. Repeated bytes, periodic strings, 0x00/0xFF mixes and a block closed by the length limit make these paths occur many times per block.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

    localparam int SYM_W  = 8;
    localparam int ALPHA  = 256;
    localparam int CODE_W = 9;
    localparam logic [CODE_W-1:0] SENT_CODE = 9'd256;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_INIT,
        ST_SCAN,
        ST_INSERT,
        ST_READ,
        ST_DONE
    } state_t;

    typedef struct packed {
        logic             found;
        logic [SYM_W-1:0] sym;
    } below_t;

    // Largest symbol value strictly below c whose group is non-empty.
    function automatic below_t highest_below(input logic [ALPHA-1:0] vld,
                                             input logic [SYM_W-1:0] c);
        below_t r;
        r = '0;
        for (int k = 0; k < ALPHA; k++) begin
            if (vld[k] && (k < int'(c))) begin
                r.found = 1'b1;
                r.sym   = SYM_W'(k);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/bwt_sym_store.sv
module bwt_sym_store #(
    parameter int AW = 7
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [7:0]       wdata,
    input  logic [AW-1:0]    raddr_a,
    output logic [7:0]       rdata_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [7:0]       rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/bwt_link_ram.sv
module bwt_link_ram #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_a,
    input  logic [AW-1:0] waddr_a,
    input  logic [AW-1:0] wdata_a,
    input  logic          we_b,
    input  logic [AW-1:0] waddr_b,
    input  logic [AW-1:0] wdata_b,
    input  logic [AW-1:0] raddr_a,
    output logic [AW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [AW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [AW-1:0] nxt [DEPTH];

    always_ff @(posedge clk) begin
        if (we_a) nxt[waddr_a] <= wdata_a;
        if (we_b) nxt[waddr_b] <= wdata_b;
    end

    assign rdata_a = nxt[raddr_a];
    assign rdata_b = nxt[raddr_b];

    // R4: an insertion rewrites two distinct pointers
    p_two_ptr_distinct_r4: assert property (@(posedge clk) disable iff (rst)
        (we_a && we_b) |-> (waddr_a != waddr_b));
endmodule

// File: rtl/bwt_group_table.sv
module bwt_group_table
    import bwt_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             we,
    input  logic [SYM_W-1:0] sym,
    input  logic [AW-1:0]    wval,
    output logic             sym_vld,
    output logic [AW-1:0]    sym_tail,
    output logic             below_found,
    output logic [AW-1:0]    below_tail
);
    logic [ALPHA-1:0] vld;
    logic [AW-1:0]    tail_mem [ALPHA];
    below_t           below;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            vld <= '0;
        end else if (we) begin
            vld[sym] <= 1'b1;
        end
        if (we) tail_mem[sym] <= wval;
    end

    always_comb begin
        below       = highest_below(vld, sym);
        below_found = below.found;
        below_tail  = tail_mem[below.sym];
        sym_vld     = vld[sym];
        sym_tail    = tail_mem[sym];
    end

    // R9: a cleared table holds no group for the next block
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (rst)
        clear |=> (vld == '0));
endmodule

// File: rtl/bwt_ass_engine.sv
module bwt_ass_engine
    import bwt_pkg::*;
#(
    parameter  int MAX_LEN = 64,
    localparam int IW      = $clog2(MAX_LEN + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_sent,
    output logic          out_last,
    output logic          idx_valid,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] NIL      = '1;
    localparam logic [IW-1:0] LAST_POS = IW'(MAX_LEN - 1);

    state_t        state;
    logic [IW-1:0] wr_cnt, blk_len, cur, ptr, head, fpred, pos, idx_r;
    logic          found;

    logic          accept;
    logic [7:0]    sym_cur, sym_prev;
    logic [CODE_W-1:0] cur_code, prev_code;
    logic [IW-1:0] tgt, nxt_ptr, nxt_pred, pred, new_head;
    logic          at_head;
    logic          grp_vld, grp_below_found, grp_we;
    logic [IW-1:0] grp_tail, grp_below_tail;
    logic          lk_we_a, lk_we_b;
    logic [IW-1:0] lk_addr_a, lk_data_a;

    assign in_ready  = (state == ST_LOAD);
    assign accept    = in_valid && in_ready;
    assign idx_valid = (state == ST_DONE);
    assign idx       = idx_r;

    bwt_sym_store #(.AW(IW)) u_syms (
        .clk     (clk),
        .we      (accept),
        .waddr   (wr_cnt),
        .wdata   (in_data),
        .raddr_a (cur),
        .rdata_a (sym_cur),
        .raddr_b (ptr - 1'b1),
        .rdata_b (sym_prev)
    );

    assign cur_code  = {1'b0, sym_cur};
    assign prev_code = (ptr == '0) ? SENT_CODE : {1'b0, sym_prev};
    assign tgt       = cur + 1'b1;

    bwt_group_table #(.AW(IW)) u_groups (
        .clk         (clk),
        .rst         (rst),
        .clear       (state == ST_INIT),
        .we          (grp_we),
        .sym         (sym_cur),
        .wval        (cur),
        .sym_vld     (grp_vld),
        .sym_tail    (grp_tail),
        .below_found (grp_below_found),
        .below_tail  (grp_below_tail)
    );

    // Where suffix cur goes: after the last smaller member of its own group,
    // else after the tail of the nearest smaller group, else at the head.
    always_comb begin
        at_head = 1'b0;
        pred    = '0;
        if (found)                pred = fpred;
        else if (grp_below_found) pred = grp_below_tail;
        else                      at_head = 1'b1;
    end
    assign new_head = at_head ? cur : head;
    assign grp_we   = (state == ST_INSERT) &&
                      (!grp_vld || (found && (fpred == grp_tail)));

    assign lk_we_a   = (state == ST_INIT) || (state == ST_INSERT);
    assign lk_addr_a = (state == ST_INIT) ? blk_len : cur;
    assign lk_data_a = (state == ST_INIT) ? NIL : (at_head ? head : nxt_pred);
    assign lk_we_b   = (state == ST_INSERT) && !at_head;

    bwt_link_ram #(.AW(IW)) u_links (
        .clk     (clk),
        .rst     (rst),
        .we_a    (lk_we_a),
        .waddr_a (lk_addr_a),
        .wdata_a (lk_data_a),
        .we_b    (lk_we_b),
        .waddr_b (pred),
        .wdata_b (cur),
        .raddr_a (ptr),
        .rdata_a (nxt_ptr),
        .raddr_b (pred),
        .rdata_b (nxt_pred)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_LOAD;
            wr_cnt    <= '0;
            blk_len   <= '0;
            cur       <= '0;
            ptr       <= '0;
            head      <= '0;
            fpred     <= '0;
            found     <= 1'b0;
            pos       <= '0;
            idx_r     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sent  <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            unique case (state)
                ST_LOAD: begin
                    if (accept) begin
                        if (in_last || (wr_cnt == LAST_POS)) begin
                            blk_len <= wr_cnt + 1'b1;
                            wr_cnt  <= '0;
                            state   <= ST_INIT;
                        end else begin
                            wr_cnt <= wr_cnt + 1'b1;
                        end
                    end
                end
                ST_INIT: begin
                    head  <= blk_len;
                    ptr   <= blk_len;
                    cur   <= blk_len - 1'b1;
                    found <= 1'b0;
                    state <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (ptr == tgt) begin
                        state <= ST_INSERT;
                    end else begin
                        if (prev_code == cur_code) begin
                            found <= 1'b1;
                            fpred <= ptr - 1'b1;
                        end
                        ptr <= nxt_ptr;
                    end
                end
                ST_INSERT: begin
                    head  <= new_head;
                    ptr   <= new_head;
                    found <= 1'b0;
                    if (cur == '0) begin
                        pos   <= '0;
                        state <= ST_READ;
                    end else begin
                        cur   <= cur - 1'b1;
                        state <= ST_SCAN;
                    end
                end
                ST_READ: begin
                    out_valid <= 1'b1;
                    out_sent  <= (ptr == '0);
                    out_data  <= (ptr == '0) ? 8'd0 : sym_prev;
                    out_last  <= (nxt_ptr == NIL);
                    if (ptr == '0) idx_r <= pos;
                    pos <= pos + 1'b1;
                    ptr <= nxt_ptr;
                    if (nxt_ptr == NIL) state <= ST_DONE;
                end
                ST_DONE: begin
                    state <= ST_LOAD;
                end
                default: state <= ST_LOAD;
            endcase
        end
    end

    // Sentinel beats seen so far in the current block
    logic [1:0] sent_seen;
    always_ff @(posedge clk) begin
        if (rst || in_ready)          sent_seen <= '0;
        else if (out_valid && out_sent) sent_seen <= sent_seen + 1'b1;
    end

    p_busy_not_ready_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);
    p_last_has_idx_r6: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (idx_valid && out_valid));
    p_idx_only_last_r6: assert property (@(posedge clk) disable iff (rst)
        idx_valid |-> out_last);
    p_sent_data_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sent) |-> (out_data == 8'd0));
    p_one_sentinel_r5: assert property (@(posedge clk) disable iff (rst)
        out_last |-> ((sent_seen + {1'b0, out_sent}) == 2'd1));
    p_scan_in_list_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCAN) |-> (ptr != NIL));
    p_idx_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        idx_valid |-> (idx <= blk_len));
    p_ready_back_r9: assert property (@(posedge clk) disable iff (rst)
        idx_valid |=> in_ready);
endmodule

// File: tb/bwt_ass_engine_test.sv
`timescale 1ns/1ps
module bwt_ass_engine_test;
    localparam int MAXL = 64;
    localparam int IW   = $clog2(MAXL + 2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = '0;
    logic          in_last = 1'b0;
    logic          out_valid, out_sent, out_last, idx_valid;
    logic [7:0]    out_data;
    logic [IW-1:0] idx;

    int checks = 0;
    int errors = 0;

    logic [7:0] stim [MAXL];
    int exp_code [MAXL + 1];
    int got_code [2 * MAXL + 4];
    int rot [MAXL + 1];
    logic [31:0] seed = 32'h1234_5678;

    bwt_ass_engine #(.MAX_LEN(MAXL)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_data(out_data), .out_sent(out_sent),
        .out_last(out_last), .idx_valid(idx_valid), .idx(idx)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int code_at(input int p, input int len);
        return (p == len) ? 256 : int'(stim[p]);
    endfunction

    function automatic int cmp_rot(input int a, input int b, input int len);
        for (int k = 0; k <= len; k++) begin
            int ca = code_at((a + k) % (len + 1), len);
            int cb = code_at((b + k) % (len + 1), len);
            if (ca != cb) return (ca < cb) ? -1 : 1;
        end
        return 0;
    endfunction

    // Reference: sort all rotations, take the symbol before each
    function automatic int build_ref(input int len);
        int pidx = 0;
        for (int r = 0; r <= len; r++) rot[r] = r;
        for (int a = 1; a <= len; a++) begin
            int key = rot[a];
            int b = a - 1;
            while (b >= 0 && cmp_rot(rot[b], key, len) > 0) begin
                rot[b + 1] = rot[b];
                b--;
            end
            rot[b + 1] = key;
        end
        for (int r = 0; r <= len; r++) begin
            exp_code[r] = code_at((rot[r] + len) % (len + 1), len);
            if (rot[r] == 0) pidx = r;
        end
        return pidx;
    endfunction

    function automatic logic [7:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[23:16];
    endfunction

    // Send len bytes (in_last on the final one unless no_last), then check the block.
    task automatic run_block(input string name, input int len, input bit no_last);
        int exp_idx, nb, nsent, cyc, got_idx, first_bad;
        bit done, rdy_bad, last_bad, sent_bad;
        exp_idx = build_ref(len);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = stim[k];
            in_last  = (k == len - 1) && !no_last;
            while (!in_ready) @(negedge clk);
        end
        nb = 0; nsent = 0; cyc = 0; got_idx = -1; first_bad = -1;
        done = 0; rdy_bad = 0; last_bad = 0; sent_bad = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            cyc++;
            if (in_ready) rdy_bad = 1;
            if (out_valid) begin
                if (nb < 2 * MAXL + 4) got_code[nb] = out_sent ? 256 : int'(out_data);
                if (out_sent) begin
                    nsent++;
                    if (out_data != 8'd0) sent_bad = 1;
                end
                if (out_last != idx_valid) last_bad = 1;
                if (out_last) begin
                    done = 1;
                    got_idx = int'(idx);
                end
                nb++;
            end else if (idx_valid || out_last) begin
                last_bad = 1;
            end
        end
        $display("block %s len=%0d", name, len);
        check(nb == len + 1, "R2 beat count", nb, len + 1);
        check(!rdy_bad, "R3 in_ready low while busy", rdy_bad, 0);
        for (int r = 0; r <= len && r < nb; r++)
            if (first_bad < 0 && got_code[r] != exp_code[r]) first_bad = r;
        if (first_bad >= 0)
            check(0, "R4 output symbol", got_code[first_bad], exp_code[first_bad]);
        else
            check(1, "R4 output symbol", 0, 0);
        check(nsent == 1 && !sent_bad, "R5 sentinel beats", nsent, 1);
        check(!last_bad, "R6 last/idx alignment", last_bad, 0);
        check(got_idx == exp_idx, "R7 primary index", got_idx, exp_idx);
        @(negedge clk);
        check(in_ready && !out_valid, "R9 ready after index", in_ready, 1);
    endtask

    task automatic t_reset();
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(!out_valid && !out_last && !idx_valid, "R1 outputs idle",
              {out_valid, out_last, idx_valid}, 0);
    endtask

    task automatic t_banana();
        string s = "BANANA";
        for (int k = 0; k < 6; k++) stim[k] = s[k];
        run_block("banana_R4_R7", 6, 0);
    endtask

    task automatic t_single();          // R8
        stim[0] = 8'h41;
        run_block("single_R8", 1, 0);
    endtask

    task automatic t_all_same();        // R8, full length with in_last
        for (int k = 0; k < MAXL; k++) stim[k] = 8'h7a;
        run_block("repeat_R8", MAXL, 0);
    endtask

    task automatic t_periodic();        // R8
        for (int k = 0; k < 30; k++) stim[k] = (k % 3 == 2) ? 8'h63 : ((k % 3 == 0) ? 8'h61 : 8'h62);
        run_block("periodic_R8", 30, 0);
    endtask

    task automatic t_extremes();        // R4: 0xFF ranks below the sentinel
        for (int k = 0; k < 17; k++) stim[k] = (next_rand() > 8'd100) ? 8'hff : 8'h00;
        run_block("ff00_R4", 17, 0);
    endtask

    task automatic t_random();
        for (int k = 0; k < 40; k++) stim[k] = next_rand();
        run_block("random_R4", 40, 0);
    endtask

    task automatic t_small_alpha();     // R9: follows other blocks
        for (int k = 0; k < 25; k++) stim[k] = 8'h30 + (next_rand() & 8'h03);
        run_block("small_alpha_R9", 25, 0);
    endtask

    task automatic t_len_limit();       // R2: closes at MAXL without in_last
        for (int k = 0; k < MAXL; k++) stim[k] = 8'h40 + (next_rand() & 8'h07);
        run_block("len_limit_R2", MAXL, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_banana();
        t_single();
        t_all_same();
        t_periodic();
        t_extremes();
        t_random();
        t_small_alpha();
        t_len_limit();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule